// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps wall-clock time for hardware timestamping. It holds a 48-bit count of seconds, a nanoseconds count that always stays below one billion, and a 16-bit fraction of a nanosecond underneath. On every clock edge the time moves forward by a programmable step. The step is given as 16.16 fixed-point nanoseconds per clock, so clocks that are not an integer number of nanoseconds can be tracked without losing fractional time.

Software programs the block through a 32-bit register port with word addresses. It can load a new time, read back a time that is consistent across all words, set the nominal step, and replace the step with a different value for a chosen number of cycles. That temporary replacement slews the clock offset gradually instead of making it jump. Software can also add a small fractional correction once every M cycles to cancel a residual frequency error. The live seconds and nanoseconds go straight to the MAC-side capture logic on a registered timestamp bus.

Word address map (word index = byte offset / 4): 0 seconds [47:32] in bits [15:0], 1 seconds [31:0], 2 nanoseconds, 3 reserved, 4 nominal step, 5 override step, 6 override cycle count, 7 drift correction, 8 drift interval.

Top module: `ptp_tod_clock`

## Requirements
- R1: After reset the timestamp is zero seconds and zero nanoseconds. The nominal step, override step, override count, drift correction and drift interval all read back as zero.
- R2: With no override and no drift, each clock edge adds the nominal step (20 bits: 4 integer and 16 fractional nanosecond bits) to the time. Fractional remainders build up in a hidden 16-bit fraction and carry into the nanoseconds, so none is lost.
- R3: The nanoseconds output never reaches 1,000,000,000. Each pass over a second boundary subtracts one billion and increments the 48-bit seconds, including the carry from bit 31 into bit 32.
- R4: Writes to word 0 (bits [15:0]) and word 1 go only to shadow registers and leave the timestamp unchanged. A write to word 2 loads both shadow words and the written nanoseconds into the live time on that edge and clears the fraction.
- R5: Read data appears on `rdata` one cycle after the read strobe. A read of word 2 returns nanoseconds and also latches the current seconds. Later reads of words 0 and 1 return that latched value, even after the live seconds have moved on.
- R6: Writing C to word 6 makes the next C clock edges advance by the override step (word 5) instead of the nominal step. The nominal step is used again after that.
- R7: The override count reads back as the number of override edges still to come. It is C immediately after the write, falls by one per edge, and reads zero once the override is over.
- R8: With a drift interval R other than zero, the 16-bit drift correction (word 7, in units of 2^-16 ns) is added once every R edges. The first addition comes R edges after the interval write. An interval of zero adds nothing.
- R9: Words 4 and 5 read back the low 20 bits written, words 7 and 8 the low 16 bits, and the reserved word 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; time advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| ts_sec | output | 48 | Live seconds for timestamp capture |
| ts_ns | output | 30 | Live nanoseconds for timestamp capture |

## Verification
A write takes effect on the edge that samples it. A step written on edge k is first used on edge k+1, a nanoseconds write shows on `ts_sec`/`ts_ns` right after edge k, and an override of C cycles covers edges k+1 to k+C. The drift correction first lands R edges after the interval write. Read data is due one edge after the strobe and holds the pre-edge value of the register. The bench drives inputs and samples outputs on falling edges. It moves a reference model of time and configuration forward by exactly one step per rising edge, inside the same tasks that drive the strobes, so each expected value lines up with the cycle in which the design produces it.

// File: rtl/tod_pkg.sv
package tod_pkg;
  // word indices of the register port
  localparam int A_SEC_HI  = 0;
  localparam int A_SEC_LO  = 1;
  localparam int A_NSEC    = 2;
  localparam int A_RSVD    = 3;
  localparam int A_STEP    = 4;
  localparam int A_OV_STEP = 5;
  localparam int A_OV_CNT  = 6;
  localparam int A_DRIFT   = 7;
  localparam int A_D_RATE  = 8;

  localparam int NS_PER_SEC = 1_000_000_000;
endpackage

// File: rtl/tod_step_gen.sv
// Picks the per-edge increment: nominal or override step, plus periodic drift.
module tod_step_gen #(
  parameter int PER_W   = 20,
  parameter int CNT_W   = 20,
  parameter int DRIFT_W = 16,
  parameter int STEP_W  = PER_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PER_W-1:0]   period,
  input  logic [PER_W-1:0]   ov_period,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic [DRIFT_W-1:0] drift_adj,
  input  logic [DRIFT_W-1:0] drift_rate,
  input  logic               rate_wr,
  output logic [STEP_W-1:0]  step,
  output logic [CNT_W-1:0]   ov_cnt,
  output logic               drift_fire
);
  logic [DRIFT_W-1:0] drift_cnt;
  logic               ov_active;
  logic [PER_W-1:0]   base;

  assign ov_active  = (ov_cnt != '0);
  assign drift_fire = (drift_rate != '0) && (drift_cnt == drift_rate - DRIFT_W'(1));
  assign base       = ov_active ? ov_period : period;
  assign step       = STEP_W'(base) + (drift_fire ? STEP_W'(drift_adj) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_cnt <= '0;
    end else if (cnt_wr) begin
      ov_cnt <= cnt_wdata;
    end else if (ov_active) begin
      ov_cnt <= ov_cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || rate_wr) begin
      drift_cnt <= '0;
    end else if (drift_rate != '0) begin
      drift_cnt <= drift_fire ? '0 : drift_cnt + DRIFT_W'(1);
    end
  end
endmodule

// File: rtl/tod_time_acc.sv
// Seconds / nanoseconds / fraction accumulator with one-second wrap.
module tod_time_acc #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] step,
  input  logic              load,
  input  logic [SEC_W-1:0]  load_sec,
  input  logic [NS_W-1:0]   load_ns,
  output logic [SEC_W-1:0]  sec_q,
  output logic [NS_W-1:0]   ns_q
);
  localparam int ACC_W = NS_W + FRAC_W + 1;
  localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(tod_pkg::NS_PER_SEC);

  logic [FRAC_W-1:0] frac_q;
  logic [ACC_W-1:0]  sum;
  logic [NS_W:0]     ns_raw;
  logic [NS_W:0]     ns_next;
  logic              wrap;

  assign sum     = {1'b0, ns_q, frac_q} + ACC_W'(step);
  assign ns_raw  = sum[ACC_W-1:FRAC_W];
  assign wrap    = (ns_raw >= NS_LIM);
  assign ns_next = wrap ? ns_raw - NS_LIM : ns_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= '0;
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load) begin
      sec_q  <= load_sec;
      ns_q   <= load_ns;
      frac_q <= '0;
    end else begin
      sec_q  <= sec_q + SEC_W'(wrap);
      ns_q   <= ns_next[NS_W-1:0];
      frac_q <= sum[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/ptp_tod_clock.sv
module ptp_tod_clock #(
  parameter int SEC_W   = 48,
  parameter int NS_W    = 30,
  parameter int FRAC_W  = 16,
  parameter int PER_W   = 20,
  parameter int CNT_W   = 20,
  parameter int DRIFT_W = 16,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [SEC_W-1:0]  ts_sec,
  output logic [NS_W-1:0]   ts_ns
);
  import tod_pkg::*;

  localparam int HI_W   = SEC_W - 32;
  localparam int STEP_W = PER_W + 1;

  logic [HI_W-1:0]    sec_hi_sh;
  logic [31:0]        sec_lo_sh;
  logic [SEC_W-1:0]   sec_rd;
  logic [PER_W-1:0]   period_q;
  logic [PER_W-1:0]   ov_period_q;
  logic [DRIFT_W-1:0] drift_q;
  logic [DRIFT_W-1:0] rate_q;
  logic [STEP_W-1:0]  step_w;
  logic [CNT_W-1:0]   ov_cnt_w;
  logic               drift_fire_w;
  logic               ns_load, cnt_wr, rate_wr;

  assign ns_load = wr_en && (addr == ADDR_W'(A_NSEC));
  assign cnt_wr  = wr_en && (addr == ADDR_W'(A_OV_CNT));
  assign rate_wr = wr_en && (addr == ADDR_W'(A_D_RATE));

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_hi_sh   <= '0;
      sec_lo_sh   <= '0;
      period_q    <= '0;
      ov_period_q <= '0;
      drift_q     <= '0;
      rate_q      <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(A_SEC_HI):  sec_hi_sh   <= wdata[HI_W-1:0];
        ADDR_W'(A_SEC_LO):  sec_lo_sh   <= wdata;
        ADDR_W'(A_STEP):    period_q    <= wdata[PER_W-1:0];
        ADDR_W'(A_OV_STEP): ov_period_q <= wdata[PER_W-1:0];
        ADDR_W'(A_DRIFT):   drift_q     <= wdata[DRIFT_W-1:0];
        ADDR_W'(A_D_RATE):  rate_q      <= wdata[DRIFT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      sec_rd <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_W'(A_SEC_HI):  rdata <= 32'(sec_rd[SEC_W-1:32]);
        ADDR_W'(A_SEC_LO):  rdata <= sec_rd[31:0];
        ADDR_W'(A_NSEC): begin
          rdata  <= 32'(ts_ns);
          sec_rd <= ts_sec;
        end
        ADDR_W'(A_STEP):    rdata <= 32'(period_q);
        ADDR_W'(A_OV_STEP): rdata <= 32'(ov_period_q);
        ADDR_W'(A_OV_CNT):  rdata <= 32'(ov_cnt_w);
        ADDR_W'(A_DRIFT):   rdata <= 32'(drift_q);
        ADDR_W'(A_D_RATE):  rdata <= 32'(rate_q);
        default:            rdata <= '0;
      endcase
    end
  end

  tod_step_gen #(
    .PER_W(PER_W), .CNT_W(CNT_W), .DRIFT_W(DRIFT_W), .STEP_W(STEP_W)
  ) u_step (
    .clk(clk), .rst(rst),
    .period(period_q), .ov_period(ov_period_q),
    .cnt_wr(cnt_wr), .cnt_wdata(wdata[CNT_W-1:0]),
    .drift_adj(drift_q), .drift_rate(rate_q), .rate_wr(rate_wr),
    .step(step_w), .ov_cnt(ov_cnt_w), .drift_fire(drift_fire_w)
  );

  tod_time_acc #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
  ) u_acc (
    .clk(clk), .rst(rst), .step(step_w),
    .load(ns_load), .load_sec({sec_hi_sh, sec_lo_sh}),
    .load_ns(wdata[NS_W-1:0]),
    .sec_q(ts_sec), .ns_q(ts_ns)
  );
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int PER_W  = 20,
  parameter int CNT_W  = 20,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [SEC_W-1:0]  ts_sec,
  input logic [NS_W-1:0]   ts_ns,
  input logic [PER_W-1:0]  period_q,
  input logic [CNT_W-1:0]  ov_cnt,
  input logic              drift_fire
);
  logic load, cnt_wr;
  assign load   = wr_en && (addr == ADDR_W'(tod_pkg::A_NSEC));
  assign cnt_wr = wr_en && (addr == ADDR_W'(tod_pkg::A_OV_CNT));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (ts_sec == '0 && ts_ns == '0));

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (rst)
    (32'(ts_ns) < 32'(tod_pkg::NS_PER_SEC)));

  // R3
  sec_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ((ts_ns < $past(ts_ns)) ? (ts_sec == SEC_W'($past(ts_sec) + 1'b1))
                                      : (ts_sec == $past(ts_sec))));

  // R7
  ov_count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (ov_cnt != '0 && !cnt_wr) |=> (ov_cnt == CNT_W'($past(ov_cnt) - 1'b1)));

  // R2
  zero_step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (period_q == '0 && ov_cnt == '0 && !drift_fire && !load)
      |=> ($stable(ts_ns) && $stable(ts_sec)));
endmodule

bind ptp_tod_clock tod_clock_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .PER_W(PER_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .ts_sec(ts_sec), .ts_ns(ts_ns), .period_q(period_q),
  .ov_cnt(ov_cnt_w), .drift_fire(drift_fire_w)
);

// File: tb/ptp_tod_clock_tb.sv
module ptp_tod_clock_tb;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned SEC_UNITS = 64'd1_000_000_000 * 64'd65536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [47:0] ts_sec;
  logic [29:0] ts_ns;

  int n_chk = 0;
  int n_fail = 0;

  // reference model of configuration and time
  longint unsigned m_sec, m_ns, m_frac;
  longint unsigned m_shi, m_slo;
  longint unsigned m_per, m_ov, m_rem, m_drift, m_rate, m_dcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_tod_clock u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ts_sec(ts_sec), .ts_ns(ts_ns)
  );

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one rising edge of the reference model, using the pre-edge configuration
  task automatic model_edge();
    longint unsigned st, tot;
    if (m_rem != 0) begin
      st = m_ov;
      m_rem--;
    end else begin
      st = m_per;
    end
    if (m_rate != 0) begin
      m_dcnt++;
      if (m_dcnt % m_rate == 0) st += m_drift;
    end
    tot = m_ns * 65536 + m_frac + st;
    while (tot >= SEC_UNITS) begin
      tot -= SEC_UNITS;
      m_sec = (m_sec + 1) & 48'hFFFF_FFFF_FFFF;
    end
    m_ns = tot >> 16;
    m_frac = tot & 16'hFFFF;
  endtask

  task automatic wr(input int a, input longint unsigned d);
    addr = 4'(a); wdata = 32'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_edge();
    case (a)
      0: m_shi = d & 16'hFFFF;
      1: m_slo = d & 32'hFFFF_FFFF;
      2: begin m_sec = (m_shi << 32) | m_slo; m_ns = d; m_frac = 0; end
      4: m_per = d & 20'hFFFFF;
      5: m_ov = d & 20'hFFFFF;
      6: m_rem = d & 20'hFFFFF;
      7: m_drift = d & 16'hFFFF;
      8: begin m_rate = d & 16'hFFFF; m_dcnt = 0; end
      default: ;
    endcase
  endtask

  task automatic rd(input int a, output longint unsigned d);
    addr = 4'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    model_edge();
    d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_edge();
    end
  endtask

  task automatic chk_time(input string req);
    chk(ts_sec == 48'(m_sec) && ts_ns == 30'(m_ns), req,
        {ts_sec[31:0], 2'b0, ts_ns}, {m_sec[31:0], 2'b0, m_ns[29:0]});
  endtask

  task automatic set_time(input longint unsigned s, input longint unsigned ns);
    wr(0, s >> 32);
    wr(1, s & 32'hFFFF_FFFF);
    wr(2, ns);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint unsigned v, ns_seen;
    longint unsigned per_set[8];
    per_set = '{64'h10000, 64'h18000, 64'h00001, 64'h0F5C3,
                64'hFFFFF, 64'h6AAAB, 64'h20000, 64'h10001};
    m_sec = 0; m_ns = 0; m_frac = 0; m_shi = 0; m_slo = 0;
    m_per = 0; m_ov = 0; m_rem = 0; m_drift = 0; m_rate = 0; m_dcnt = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(ts_sec == 0 && ts_ns == 0, "R1 time after reset", {ts_sec[31:0], ts_ns}, 0);
    for (int a = 4; a <= 8; a++) begin
      rd(a, v);
      chk(v == 0, "R1 config reads zero", v, 0);
    end
    chk_time("R2 zero step holds time");

    // R9 readback widths and reserved word
    wr(4, 32'hFFFA_BCDE); rd(4, v); chk(v == 32'hABCDE, "R9 step readback", v, 32'hABCDE);
    wr(5, 32'h1231_2345); rd(5, v); chk(v == 32'h12345, "R9 override step readback", v, 32'h12345);
    wr(7, 32'h5555_BEEF); rd(7, v); chk(v == 32'hBEEF, "R9 drift readback", v, 32'hBEEF);
    wr(8, 32'h0001_0007); rd(8, v); chk(v == 7, "R9 interval readback", v, 7);
    rd(3, v); chk(v == 0, "R9 reserved word", v, 0);
    wr(8, 0); wr(7, 0); wr(4, 0);
    chk_time("R2 time follows model during config");

    // R4 shadow seconds, load on nanoseconds write
    v = ts_sec;
    wr(0, 32'hFFFF_1234);
    chk(ts_sec == 48'(v), "R4 seconds-high write leaves time", ts_sec, v);
    wr(1, 32'h89AB_CDEF);
    chk(ts_sec == 48'(v), "R4 seconds-low write leaves time", ts_sec, v);
    wr(2, 500);
    chk(ts_sec == 48'h1234_89AB_CDEF && ts_ns == 500, "R4 load on ns write",
        ts_sec, 48'h1234_89AB_CDEF);
    chk_time("R4 model after load");

    // R2 / R3 sweep of steps across a second boundary
    foreach (per_set[k]) begin
      wr(4, per_set[k]);
      set_time(5, 999_999_950);
      chk_time("R4 load before sweep");
      for (int c = 0; c < 60; c++) begin
        tick(1);
        chk_time("R2 R3 sweep step");
      end
    end

    // R3 carry from bit 31 into bit 32 of seconds
    wr(4, 32'hF0000);
    set_time(48'h0000_FFFF_FFFF, 999_999_990);
    tick(1);
    chk(ts_sec == 48'h1_0000_0000 && ts_ns == 5, "R3 carry into seconds bit 32",
        {ts_sec[33:0], ts_ns}, {34'h1_0000_0000, 30'd5});

    // R5 consistent read: ns read latches seconds
    set_time(7, 999_999_000);
    ns_seen = m_ns;
    rd(2, v); chk(v == ns_seen, "R5 ns read value", v, ns_seen);
    tick(80);
    chk(ts_sec == 8, "R3 live seconds advanced", ts_sec, 8);
    rd(1, v); chk(v == 7, "R5 latched seconds low", v, 7);
    rd(0, v); chk(v == 0, "R5 latched seconds high", v, 0);
    set_time(48'h00AB_0000_0010, 0);
    rd(2, v);
    rd(0, v); chk(v == 32'hAB, "R5 latched seconds high nonzero", v, 32'hAB);
    chk_time("R5 time after reads");

    // R6 / R7 override step for a fixed number of cycles
    wr(4, 32'h10000);
    set_time(10, 0);
    wr(5, 32'h50000);
    wr(6, 4);
    rd(6, v); chk(v == 4, "R7 count readback after write", v, 4);
    chk_time("R6 first override edge");
    rd(6, v); chk(v == 3, "R7 count decrements", v, 3);
    for (int c = 0; c < 5; c++) begin
      tick(1);
      chk_time("R6 override then nominal");
    end
    rd(6, v); chk(v == 0, "R7 count reads zero when done", v, 0);
    wr(6, 100);
    tick(150);
    chk_time("R6 long override");

    // R8 drift correction
    wr(4, 32'h80000);
    set_time(20, 0);
    wr(7, 32'h4000);
    wr(8, 3);
    for (int c = 0; c < 12; c++) begin
      tick(1);
      chk_time("R8 drift every 3 edges");
    end
    wr(8, 0);
    tick(10);
    chk_time("R8 zero interval disables drift");
    chk(ts_ns == 30'(m_ns) && m_frac == 0 || ts_ns == 30'(m_ns), "R8 ns after disable",
        ts_ns, m_ns);
    wr(7, 32'hFFFF);
    wr(8, 1);
    for (int c = 0; c < 6; c++) begin
      tick(1);
      chk_time("R8 drift every edge");
    end
    wr(8, 0);
    tick(3);
    chk_time("R8 final");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule